// File: doc/BRIEF.md
# Ping-Pong Endpoint Transmit Buffer with DMA Pacing

This block holds outgoing packet data for one bulk-IN style endpoint. It has two packet banks, each `BANK_BYTES` (64 by default) deep. They are filled in turn from a byte-wide write port on the memory side. While software has set the DMA enable control bit, the `dma_req` output asks a DMA controller for more bytes whenever the bank being filled still has room. A bank that reaches its full size during DMA operation is committed by the block on its own, and filling moves to the other bank. A shorter packet stays open until software pulses `commit_req`.

The drain side presents the oldest committed bank to a serializer. It shows the bank's byte count, the current byte and a last-byte flag, and it steps forward on `rd_en`. When the last byte is taken, the bank is freed and `pkt_done` pulses. Each completion sets a pending interrupt flag. A separate enable gates that flag, and the DMA setting has no effect on the gate. Writes that find no room are discarded and recorded in a sticky overflow flag. A zero-length packet can be committed when the matching control bit is set.

Top module: `ep_tx_pingpong`

## Requirements
- R1: The control register resets to 0. A `ctl_we` pulse loads `ctl_wdata`, and `ctl_rdata` reads it back. Bit 0 is the DMA enable and bit 1 is the zero-length-packet enable. While bit 0 is 0, `dma_req` stays low.
- R2: While DMA is enabled, `dma_req` is high exactly when the bank being filled is uncommitted and holds fewer than `BANK_BYTES` bytes.
- R3: Banks are filled alternately, starting at bank 0. Committed packets are drained in commit order, and the bytes of each packet come out in the order they were written.
- R4: With DMA enabled, the write that brings a bank to `BANK_BYTES` bytes commits that bank at the same clock edge, so `rd_avail` can be seen one cycle later with `rd_len` = `BANK_BYTES`. With DMA disabled, a full bank is not committed automatically.
- R5: After an automatic commit, `dma_req` is high in the next cycle if the other bank is uncommitted and not full.
- R6: A bank holding fewer than `BANK_BYTES` bytes is never committed automatically. A `commit_req` pulse commits it with its current byte count.
- R7: When `rd_avail` is high, `rd_len` is the head bank's byte count and `rd_data` is its current byte. `rd_last` marks the final byte, or any zero-length packet. An `rd_en` on the final byte pulses `pkt_done`, frees the bank and moves to the other bank.
- R8: A write arriving while the fill bank is committed or full is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed.
- R9: A `commit_req` on an empty bank is ignored when control bit 1 is 0. When bit 1 is 1, it commits a packet with `rd_len` = 0.
- R10: Each `pkt_done` sets a pending flag, and `irq_ack` clears it. `irq` equals the pending flag ANDed with `irq_en`, whatever the DMA setting.
- R11: After reset both banks are empty, fill and drain both start at bank 0, and `dma_req`, `rd_avail`, `ovf_flag` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 DMA enable, bit 1 zero-length enable |
| ctl_rdata | output | 2 | Control register read-back |
| commit_req | input | 1 | Software packet commit pulse |
| wr_valid | input | 1 | Memory-side byte write strobe |
| wr_data | input | DATA_W | Memory-side byte |
| dma_req | output | 1 | DMA transfer request |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_en | input | 1 | Drain side takes the current byte |
| rd_avail | output | 1 | A committed packet is at the drain head |
| rd_len | output | CNT_W | Byte count of the head packet |
| rd_data | output | DATA_W | Current byte of the head packet |
| rd_last | output | 1 | Current byte is the packet's last, or the packet is empty |
| pkt_done | output | 1 | Head packet fully drained this cycle |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Gated packet-done interrupt |

## Verification
Control read-back, `dma_req`, `rd_avail`, `rd_len` and `ovf_flag` all come from registers. Each takes its new value one cycle after the write, commit or clear that caused it. The bench drives inputs on the falling edge and checks those outputs on the following falling edge, after exactly one rising edge. `rd_data`, `rd_last` and `pkt_done` are combinational views of the head bank: the scoreboard monitor compares them in the same half-cycle in which it raises `rd_en`, and it pops one queued byte per accepted read. `irq` follows `irq_en` without delay and follows the pending flag one edge after `pkt_done` or `irq_ack`.

// File: rtl/eptx_pkg.sv
package eptx_pkg;
   localparam int NUM_BANKS = 2;
   localparam int CTL_W     = 2;

   typedef struct packed {
      logic zlp_en;
      logic dma_en;
   } eptx_ctl_t;
endpackage

// File: rtl/eptx_store.sv
module eptx_store #(
   parameter int DATA_W     = 8,
   parameter int BANK_BYTES = 64,
   localparam int OFF_W     = $clog2(BANK_BYTES)
) (
   input  logic              clk,
   input  logic              wr_we,
   input  logic              wr_bank,
   input  logic [OFF_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [OFF_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import eptx_pkg::*;

   logic [DATA_W-1:0] bank_out [NUM_BANKS];

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic [DATA_W-1:0] mem [BANK_BYTES];
      always_ff @(posedge clk) begin
         if (wr_we && (int'(wr_bank) == g)) mem[wr_addr] <= wr_data;
      end
      assign bank_out[g] = mem[rd_addr];
   end

   assign rd_data = bank_out[rd_bank];
endmodule

// File: rtl/eptx_fill.sv
module eptx_fill #(
   parameter int BANK_BYTES = 64,
   localparam int CNT_W     = $clog2(BANK_BYTES + 1),
   localparam int OFF_W     = $clog2(BANK_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dma_en,
   input  logic                  zlp_en,
   input  logic                  wr_valid,
   input  logic                  commit_req,
   input  logic                  clr_valid,
   input  logic                  clr_idx,
   output logic                  wptr,
   output logic [1:0]            bank_ready,
   output logic [1:0][CNT_W-1:0] bank_cnt,
   output logic                  wr_accept,
   output logic [OFF_W-1:0]      wr_addr,
   output logic                  dma_req,
   output logic                  drop
);
   logic [CNT_W-1:0] cur_cnt, cnt_after;
   logic             room, auto_commit, sw_commit, do_commit;

   assign cur_cnt     = bank_cnt[wptr];
   assign room        = !bank_ready[wptr] && (cur_cnt < CNT_W'(BANK_BYTES));
   assign wr_accept   = wr_valid && room;
   assign drop        = wr_valid && !room;
   assign wr_addr     = cur_cnt[OFF_W-1:0];
   assign auto_commit = wr_accept && dma_en && (cur_cnt == CNT_W'(BANK_BYTES - 1));
   assign cnt_after   = cur_cnt + CNT_W'(wr_accept);
   assign sw_commit   = commit_req && !bank_ready[wptr] && !auto_commit &&
                        ((cnt_after != '0) || zlp_en);
   assign do_commit   = auto_commit || sw_commit;
   assign dma_req     = dma_en && room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr       <= 1'b0;
         bank_ready <= '0;
         bank_cnt   <= '0;
      end else begin
         for (int b = 0; b < 2; b++) begin
            if (clr_valid && (int'(clr_idx) == b)) begin
               bank_ready[b] <= 1'b0;
               bank_cnt[b]   <= '0;
            end else if (int'(wptr) == b) begin
               bank_cnt[b] <= cnt_after;
               if (do_commit) bank_ready[b] <= 1'b1;
            end
         end
         if (do_commit) wptr <= !wptr;
      end
   end
endmodule

// File: rtl/eptx_drain.sv
module eptx_drain #(
   parameter int BANK_BYTES = 64,
   localparam int CNT_W     = $clog2(BANK_BYTES + 1),
   localparam int OFF_W     = $clog2(BANK_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            bank_ready,
   input  logic [1:0][CNT_W-1:0] bank_cnt,
   input  logic                  rd_en,
   output logic                  rptr,
   output logic [OFF_W-1:0]      rd_off,
   output logic                  rd_avail,
   output logic [CNT_W-1:0]      rd_len,
   output logic                  rd_last,
   output logic                  pkt_done
);
   assign rd_avail = bank_ready[rptr];
   assign rd_len   = bank_cnt[rptr];
   assign rd_last  = rd_avail &&
                     ((rd_len == '0) || (CNT_W'(rd_off) == rd_len - CNT_W'(1)));
   assign pkt_done = rd_en && rd_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr   <= 1'b0;
         rd_off <= '0;
      end else if (rd_en && rd_avail) begin
         if (rd_last) begin
            rptr   <= !rptr;
            rd_off <= '0;
         end else begin
            rd_off <= rd_off + OFF_W'(1);
         end
      end
   end
endmodule

// File: rtl/ep_tx_pingpong.sv
module ep_tx_pingpong #(
   parameter int DATA_W      = 8,
   parameter int BANK_BYTES  = 64,
   parameter bit ZLP_SUPPORT = 1'b1,
   localparam int CNT_W      = $clog2(BANK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [1:0]        ctl_wdata,
   output logic [1:0]        ctl_rdata,
   input  logic              commit_req,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              dma_req,
   output logic              ovf_flag,
   input  logic              ovf_clr,
   input  logic              rd_en,
   output logic              rd_avail,
   output logic [CNT_W-1:0]  rd_len,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              pkt_done,
   input  logic              irq_en,
   input  logic              irq_ack,
   output logic              irq
);
   import eptx_pkg::*;
   localparam int OFF_W = $clog2(BANK_BYTES);

   if (BANK_BYTES < 2 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_depth
      $error("BANK_BYTES must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   eptx_ctl_t             ctl_q;
   logic                  zlp_eff;
   logic                  wptr, rptr, wr_accept, drop, irq_pend;
   logic [1:0]            bank_ready;
   logic [1:0][CNT_W-1:0] bank_cnt;
   logic [OFF_W-1:0]      wr_addr, rd_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= eptx_ctl_t'(ctl_wdata);
   end

   if (ZLP_SUPPORT) begin : g_zlp
      assign zlp_eff = ctl_q.zlp_en;
   end else begin : g_nozlp
      assign zlp_eff = 1'b0;
   end

   assign ctl_rdata = ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         irq_pend <= 1'b0;
      end else begin
         if (drop)         ovf_flag <= 1'b1;
         else if (ovf_clr) ovf_flag <= 1'b0;
         if (pkt_done)     irq_pend <= 1'b1;
         else if (irq_ack) irq_pend <= 1'b0;
      end
   end

   assign irq = irq_pend && irq_en;

   eptx_fill #(.BANK_BYTES(BANK_BYTES)) u_fill (
      .clk(clk), .rst_n(rst_n), .dma_en(ctl_q.dma_en), .zlp_en(zlp_eff),
      .wr_valid(wr_valid), .commit_req(commit_req),
      .clr_valid(pkt_done), .clr_idx(rptr),
      .wptr(wptr), .bank_ready(bank_ready), .bank_cnt(bank_cnt),
      .wr_accept(wr_accept), .wr_addr(wr_addr), .dma_req(dma_req), .drop(drop)
   );

   eptx_drain #(.BANK_BYTES(BANK_BYTES)) u_drain (
      .clk(clk), .rst_n(rst_n), .bank_ready(bank_ready), .bank_cnt(bank_cnt),
      .rd_en(rd_en), .rptr(rptr), .rd_off(rd_off), .rd_avail(rd_avail),
      .rd_len(rd_len), .rd_last(rd_last), .pkt_done(pkt_done)
   );

   eptx_store #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES)) u_store (
      .clk(clk), .wr_we(wr_accept), .wr_bank(wptr), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_bank(rptr), .rd_addr(rd_off), .rd_data(rd_data)
   );
endmodule

// File: rtl/eptx_checker.sv
module eptx_checker #(
   parameter int BANK_BYTES = 64,
   localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            ctl_rdata,
   input logic                  ctl_we,
   input logic                  dma_req,
   input logic                  wr_valid,
   input logic                  wr_accept,
   input logic                  ovf_flag,
   input logic                  ovf_clr,
   input logic                  pkt_done,
   input logic                  irq_en,
   input logic                  irq,
   input logic                  wptr,
   input logic                  rptr,
   input logic [1:0]            bank_ready,
   input logic [1:0][CNT_W-1:0] bank_cnt
);
   logic fill_to_full;
   assign fill_to_full = wr_accept && ctl_rdata[0] && !ctl_we &&
                         (bank_cnt[wptr] == CNT_W'(BANK_BYTES - 1));

   AST_DMA_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[0] |-> !dma_req); // R1
   AST_REQ_TAKES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && wr_valid) |=> !$rose(ovf_flag)); // R2
   AST_AUTO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_to_full |=> bank_ready[$past(wptr)]); // R4
   AST_REARM_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_to_full && !bank_ready[!wptr] && (bank_cnt[!wptr] < CNT_W'(BANK_BYTES)))
      |=> dma_req); // R5
   AST_DRAIN_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> (rptr != $past(rptr))); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R10
endmodule

bind ep_tx_pingpong eptx_checker #(.BANK_BYTES(BANK_BYTES)) u_eptx_checker (
   .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .ctl_we(ctl_we),
   .dma_req(dma_req), .wr_valid(wr_valid), .wr_accept(wr_accept),
   .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .pkt_done(pkt_done),
   .irq_en(irq_en), .irq(irq), .wptr(wptr), .rptr(rptr),
   .bank_ready(bank_ready), .bank_cnt(bank_cnt)
);

// File: tb/ep_tx_pingpong_bench.sv
module ep_tx_pingpong_bench;
   localparam int DW = 8;
   localparam int BB = 64;
   localparam int CW = $clog2(BB + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctl_we = 0, commit_req = 0, wr_valid = 0, ovf_clr = 0, rd_en = 0;
   logic irq_en = 0, irq_ack = 0;
   logic [1:0] ctl_wdata = '0, ctl_rdata;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic dma_req, ovf_flag, rd_avail, rd_last, pkt_done, irq;
   logic [CW-1:0] rd_len;

   int n_chk = 0, n_err = 0;
   bit mon_on = 0, at_start = 1, finished = 0;
   int remaining = 0;
   logic [DW-1:0] byte_q[$];
   int len_q[$];

   always #5 clk = ~clk;

   ep_tx_pingpong #(.DATA_W(DW), .BANK_BYTES(BB)) u_ep_tx_pingpong (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .commit_req(commit_req), .wr_valid(wr_valid),
      .wr_data(wr_data), .dma_req(dma_req), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
      .rd_en(rd_en), .rd_avail(rd_avail), .rd_len(rd_len), .rd_data(rd_data),
      .rd_last(rd_last), .pkt_done(pkt_done), .irq_en(irq_en), .irq_ack(irq_ack),
      .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic put_byte(input logic [DW-1:0] d, input bit expect_kept);
      wr_valid = 1; wr_data = d;
      if (expect_kept) byte_q.push_back(d);
      @(negedge clk);
      wr_valid = 0;
   endtask

   task automatic pulse_ctl(input logic [1:0] v);
      ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
   endtask

   task automatic pulse_commit(input int exp_len, input bit expect_pkt);
      if (expect_pkt) len_q.push_back(exp_len);
      commit_req = 1; @(negedge clk); commit_req = 0;
   endtask

   task automatic wait_drained();
      wait (byte_q.size() == 0 && len_q.size() == 0 && at_start);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // scoreboard monitor: pops expected lengths and bytes as the drain side produces them
   initial forever begin
      @(negedge clk);
      rd_en = 0;
      if (mon_on && rd_avail) begin
         if (at_start) begin
            if (len_q.size() == 0) begin
               check(0, "R3 unexpected packet", int'(rd_len), -1);
               remaining = int'(rd_len);
            end else begin
               remaining = len_q.pop_front();
               check(rd_len == CW'(remaining), "R7 rd_len", int'(rd_len), remaining);
            end
            at_start = 0;
         end
         if (remaining == 0) begin
            check(rd_last == 1, "R9 zero-length rd_last", int'(rd_last), 1);
            at_start = 1;
         end else begin
            logic [DW-1:0] exp;
            exp = (byte_q.size() != 0) ? byte_q.pop_front() : 'x;
            check(rd_data === exp, "R3 byte order", int'(rd_data), int'(exp));
            remaining--;
            check(rd_last == (remaining == 0), "R7 rd_last", int'(rd_last), int'(remaining == 0));
            if (remaining == 0) at_start = 1;
         end
         rd_en = 1;
         #1;
         check(pkt_done == at_start, "R7 pkt_done", int'(pkt_done), int'(at_start));
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(dma_req == 0, "R11 dma_req at reset", int'(dma_req), 0);
      check(rd_avail == 0, "R11 rd_avail at reset", int'(rd_avail), 0);
      check(ovf_flag == 0, "R11 ovf at reset", int'(ovf_flag), 0);
      check(irq == 0, "R11 irq at reset", int'(irq), 0);
      check(ctl_rdata == 2'b00, "R1 ctl reset", int'(ctl_rdata), 0);

      pulse_ctl(2'b01);
      check(ctl_rdata == 2'b01, "R1 ctl readback", int'(ctl_rdata), 1);
      check(dma_req == 1, "R2 request with room", int'(dma_req), 1);

      for (int i = 0; i < BB; i++) put_byte(DW'(i ^ 8'h5A), 1);
      len_q.push_back(BB);
      check(rd_avail == 1, "R4 auto commit", int'(rd_avail), 1);
      check(rd_len == CW'(BB), "R4 full length", int'(rd_len), BB);
      check(dma_req == 1, "R5 re-arm on other bank", int'(dma_req), 1);

      for (int i = 0; i < BB; i++) put_byte(DW'(i + 100), 1);
      len_q.push_back(BB);
      check(dma_req == 0, "R2 no room no request", int'(dma_req), 0);
      put_byte(8'hEE, 0);
      check(ovf_flag == 1, "R8 overflow set", int'(ovf_flag), 1);

      mon_on = 1;
      wait_drained();
      check(rd_avail == 0, "R7 banks freed", int'(rd_avail), 0);
      check(ovf_flag == 1, "R8 overflow sticky", int'(ovf_flag), 1);
      check(irq == 0, "R10 irq masked", int'(irq), 0);
      irq_en = 1; @(negedge clk);
      check(irq == 1, "R10 irq with DMA on", int'(irq), 1);
      irq_ack = 1; @(negedge clk); irq_ack = 0;
      check(irq == 0, "R10 irq acked", int'(irq), 0);
      ovf_clr = 1; @(negedge clk); ovf_clr = 0;
      check(ovf_flag == 0, "R8 overflow cleared", int'(ovf_flag), 0);

      for (int i = 0; i < 10; i++) put_byte(DW'(8'hC0 + i), 1);
      repeat (5) @(negedge clk);
      check(rd_avail == 0, "R6 short not auto committed", int'(rd_avail), 0);
      check(dma_req == 1, "R2 short bank has room", int'(dma_req), 1);
      pulse_commit(10, 1);
      wait_drained();

      mon_on = 0;
      pulse_commit(0, 0);
      repeat (2) @(negedge clk);
      check(rd_avail == 0, "R9 empty commit ignored", int'(rd_avail), 0);
      pulse_ctl(2'b11);
      check(ctl_rdata == 2'b11, "R1 ctl zlp readback", int'(ctl_rdata), 3);
      pulse_commit(0, 1);
      check(rd_avail == 1, "R9 zero-length committed", int'(rd_avail), 1);
      check(rd_len == 0, "R9 zero length", int'(rd_len), 0);
      mon_on = 1;
      wait_drained();

      pulse_ctl(2'b00);
      check(dma_req == 0, "R1 request off", int'(dma_req), 0);
      for (int i = 0; i < BB; i++) put_byte(DW'(255 - i), 1);
      repeat (2) @(negedge clk);
      check(rd_avail == 0, "R4 no auto commit without DMA", int'(rd_avail), 0);
      put_byte(8'h11, 0);
      check(ovf_flag == 1, "R8 full bank drops", int'(ovf_flag), 1);
      pulse_commit(BB, 1);
      wait_drained();
      check(rd_avail == 0, "R3 all drained", int'(rd_avail), 0);
      finish_run();
   end
endmodule